// File: doc/BRIEF.md
# Sample Capture Ring and Six-Bit Dump Packer

This block records paired samples, a 10-bit analog value together with an 8-bit logic value, into a circular memory of `DEPTH` entries. Software arms it through a small control byte, after which every incoming sample is written around the ring. A trigger pulse from an external trigger decision, or a force bit in the control byte, ends the pre-trigger phase. From then on exactly `POST_CNT` further samples are stored, and the block reports that data is ready.

A one-cycle status query returns a single status byte that encodes the capture state. Once that byte shows data-ready, a dump request streams the whole ring out, oldest sample first, over a valid/ready byte interface. Each sample becomes three bytes. Only the low six bits of each byte carry data, so the analog and logic values are split across byte boundaries in a fixed pattern. The dump always holds `DEPTH` samples, which is 3072 bytes at the default depth of 1024.

Top module: `smp_capture_packer`

## Requirements
- R1: After reset the state is idle, `out_valid` is 0 and a status query returns 0x10.
- R2: A control write with bit 0 set forces the idle state and rewinds the write pointer, whatever the other bits hold. A write with bit 1 set and bit 0 clear moves idle to armed and is ignored in every other state. The sequence 0x01, 0x02, 0x00 therefore leaves the block armed.
- R3: A `trig_pulse` while armed starts the post-trigger phase. In any other state it has no effect.
- R4: A control write with bit 3 set and bit 0 clear starts the post-trigger phase at once from idle or armed, with no trigger.
- R5: In the post-trigger phase exactly `POST_CNT` further samples are stored, and the state then becomes data-ready. Samples that arrive in data-ready or during a dump are not stored.
- R6: `stat_vld` is high in the cycle after `stat_req` and `stat_byte` holds the state at the request. The codes are idle 0x10, armed 0x11, post-trigger 0x12, data-ready 0x16 and dumping 0x17.
- R7: A dump request in any state other than data-ready is ignored and produces no output byte.
- R8: A dump sends `DEPTH`×3 bytes. The first sample is the one at the write pointer when capture completed, so the ring is sent oldest first. The state returns to idle after the last byte.
- R9: For a sample with analog value A and logic value L, byte 0 is {00, A[5:0]}, byte 1 is {00, L[1:0], A[9:6]} and byte 2 is {00, L[7:2]}.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` does not change.
- R11: A control write with bit 0 set during a dump ends the stream, and `out_valid` is 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_analog | input | 10 | Analog sample value |
| smp_logic | input | 8 | Logic sample value |
| trig_pulse | input | 1 | Trigger event from the external trigger decision |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_data | input | 8 | Control byte: bit 0 restart, bit 1 arm, bit 3 force |
| stat_req | input | 1 | Status query |
| stat_vld | output | 1 | Status byte valid |
| stat_byte | output | 8 | Status byte |
| dump_req | input | 1 | Dump request |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output byte |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
A control state that goes wrong shows up at the very next status query as a wrong code. It can also show up one cycle after a dump request as a stream that starts when it should not, or fails to start. A write pointer or post-trigger count that is off by one moves every byte of the dump by one whole sample, so the first compared byte already differs. A wrong packing split or a bad byte index shows within the first three bytes. A broken hold under back-pressure shows the first time `out_ready` drops. The bench sweeps several pre-trigger lengths so that the oldest-sample position lands on different ring slots, and it compares every byte of every dump.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
   localparam int ANA_W = 10;
   localparam int LOG_W = 8;
   localparam int SMP_W = ANA_W + LOG_W;

   localparam int CTL_RESTART = 0;
   localparam int CTL_ARM     = 1;
   localparam int CTL_FORCE   = 3;

   typedef enum logic [2:0] {
      S_IDLE, S_ARMED, S_POST, S_READY, S_DUMP
   } cdp_state_e;

   function automatic logic [7:0] status_code(input cdp_state_e s);
      case (s)
         S_IDLE:  return 8'h10;
         S_ARMED: return 8'h11;
         S_POST:  return 8'h12;
         S_READY: return 8'h16;
         default: return 8'h17;
      endcase
   endfunction

   // sample word layout: {logic[7:0], analog[9:0]}
   function automatic logic [7:0] pack_byte(input logic [SMP_W-1:0] smp,
                                            input logic [1:0] idx);
      case (idx)
         2'd0:    return {2'b00, smp[5:0]};
         2'd1:    return {2'b00, smp[11:10], smp[9:6]};
         2'd2:    return {2'b00, smp[17:12]};
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/cdp_ring.sv
module cdp_ring
   import cdp_pkg::*;
#(
   parameter int DEPTH = 1024,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [SMP_W-1:0] wr_data,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   output logic [SMP_W-1:0] rd_data
);
   logic [SMP_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (rd_en) rd_data <= mem[rd_addr];
   end

   AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en)); // R8
endmodule

// File: rtl/cdp_ctrl.sv
module cdp_ctrl
   import cdp_pkg::*;
#(
   parameter int DEPTH    = 1024,
   parameter int POST_CNT = 512,
   localparam int AW   = $clog2(DEPTH),
   localparam int PC_W = $clog2(POST_CNT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_wr,
   input  logic [7:0]    ctl_data,
   input  logic          trig_pulse,
   input  logic          smp_valid,
   input  logic          dump_req,
   input  logic          dump_done,
   input  logic          stat_req,
   output logic          stat_vld,
   output logic [7:0]    stat_byte,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] oldest_addr,
   output logic          dump_start,
   output logic          abort
);
   cdp_state_e      state;
   logic [AW-1:0]   wptr;
   logic [PC_W-1:0] pcnt;
   logic            arm_cmd, force_cmd;

   assign abort      = ctl_wr && ctl_data[CTL_RESTART];
   assign arm_cmd    = ctl_wr && ctl_data[CTL_ARM];
   assign force_cmd  = ctl_wr && ctl_data[CTL_FORCE];
   assign wr_en      = smp_valid && (state == S_ARMED || state == S_POST);
   assign wr_addr    = wptr;
   assign dump_start = (state == S_READY) && dump_req && !abort;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         wptr        <= '0;
         pcnt        <= '0;
         oldest_addr <= '0;
         stat_vld    <= 1'b0;
         stat_byte   <= 8'h00;
      end else begin
         stat_vld <= stat_req;
         if (stat_req) stat_byte <= status_code(state);
         if (wr_en) wptr <= wptr + 1'b1;
         if (abort) begin
            state <= S_IDLE;
            wptr  <= '0;
            pcnt  <= '0;
         end else begin
            case (state)
               S_IDLE: begin
                  if (force_cmd) begin
                     state <= S_POST;
                     pcnt  <= '0;
                  end else if (arm_cmd) begin
                     state <= S_ARMED;
                  end
               end
               S_ARMED: begin
                  if (force_cmd || trig_pulse) begin
                     state <= S_POST;
                     pcnt  <= '0;
                  end
               end
               S_POST: begin
                  if (smp_valid) begin
                     if (pcnt == PC_W'(POST_CNT - 1)) begin
                        state       <= S_READY;
                        oldest_addr <= wptr + 1'b1;
                     end else begin
                        pcnt <= pcnt + 1'b1;
                     end
                  end
               end
               S_READY: if (dump_req) state <= S_DUMP;
               default: if (dump_done) state <= S_IDLE;
            endcase
         end
      end
   end

   AST_RESTART_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> state == S_IDLE); // R2
   AST_STATUS_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      stat_req |=> stat_vld); // R6
   AST_READY_FROM_POST: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_READY && $past(state) != S_READY) |-> $past(state) == S_POST); // R5
endmodule

// File: rtl/cdp_packer.sv
module cdp_packer
   import cdp_pkg::*;
#(
   parameter int DEPTH = 1024,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AW-1:0]    start_addr,
   input  logic             abort,
   input  logic [SMP_W-1:0] rd_data,
   output logic             rd_en,
   output logic [AW-1:0]    rd_addr,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [7:0]       out_byte,
   output logic             done
);
   logic          active, fetch;
   logic [1:0]    idx;
   logic [AW-1:0] scnt;
   logic          last_smp;

   assign last_smp  = (scnt == AW'(DEPTH - 1));
   assign rd_en     = active && fetch;
   assign out_valid = active && !fetch;
   assign out_byte  = pack_byte(rd_data, idx);
   assign done      = out_valid && out_ready && (idx == 2'd2) && last_smp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         fetch   <= 1'b0;
         idx     <= 2'd0;
         scnt    <= '0;
         rd_addr <= '0;
      end else if (abort) begin
         active <= 1'b0;
         fetch  <= 1'b0;
      end else if (start) begin
         active  <= 1'b1;
         fetch   <= 1'b1;
         idx     <= 2'd0;
         scnt    <= '0;
         rd_addr <= start_addr;
      end else if (active) begin
         if (fetch) begin
            fetch <= 1'b0;
         end else if (out_ready) begin
            if (idx == 2'd2) begin
               idx <= 2'd0;
               if (last_smp) begin
                  active <= 1'b0;
               end else begin
                  scnt    <= scnt + 1'b1;
                  rd_addr <= rd_addr + 1'b1;
                  fetch   <= 1'b1;
               end
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !abort) |=> (out_valid && $stable(out_byte))); // R10
   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !active); // R7
   AST_ABORT_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !out_valid); // R11
endmodule

// File: rtl/smp_capture_packer.sv
module smp_capture_packer
   import cdp_pkg::*;
#(
   parameter int DEPTH    = 1024,
   parameter int POST_CNT = 512,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       smp_valid,
   input  logic [9:0] smp_analog,
   input  logic [7:0] smp_logic,
   input  logic       trig_pulse,
   input  logic       ctl_wr,
   input  logic [7:0] ctl_data,
   input  logic       stat_req,
   output logic       stat_vld,
   output logic [7:0] stat_byte,
   input  logic       dump_req,
   output logic       out_valid,
   output logic [7:0] out_byte,
   input  logic       out_ready
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (POST_CNT < 1 || POST_CNT > DEPTH) begin : g_bad_post
         $error("POST_CNT must lie in 1..DEPTH");
      end
   endgenerate

   logic             wr_en, rd_en, dump_start, dump_done, abort;
   logic [AW-1:0]    wr_addr, rd_addr, oldest_addr;
   logic [SMP_W-1:0] rd_data;

   cdp_ctrl #(.DEPTH(DEPTH), .POST_CNT(POST_CNT)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
      .trig_pulse(trig_pulse), .smp_valid(smp_valid), .dump_req(dump_req),
      .dump_done(dump_done), .stat_req(stat_req), .stat_vld(stat_vld),
      .stat_byte(stat_byte), .wr_en(wr_en), .wr_addr(wr_addr),
      .oldest_addr(oldest_addr), .dump_start(dump_start), .abort(abort)
   );

   cdp_ring #(.DEPTH(DEPTH)) u_ring (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data({smp_logic, smp_analog}), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data)
   );

   cdp_packer #(.DEPTH(DEPTH)) u_packer (
      .clk(clk), .rst_n(rst_n), .start(dump_start), .start_addr(oldest_addr),
      .abort(abort), .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .out_ready(out_ready), .out_valid(out_valid), .out_byte(out_byte),
      .done(dump_done)
   );
endmodule

// File: tb/smp_capture_packer_bench.sv
module smp_capture_packer_bench;
   localparam int DEPTH = 16;
   localparam int POST  = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       smp_valid = 1'b0;
   logic [9:0] smp_analog = '0;
   logic [7:0] smp_logic = '0;
   logic       trig_pulse = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_data = '0;
   logic       stat_req = 1'b0;
   logic       stat_vld;
   logic [7:0] stat_byte;
   logic       dump_req = 1'b0;
   logic       out_valid;
   logic [7:0] out_byte;
   logic       out_ready = 1'b1;

   int checks = 0;
   int fails = 0;
   bit finished = 0;
   int ha [256];
   int hl [256];
   int n = 0;

   always #4 clk = ~clk;

   smp_capture_packer #(.DEPTH(DEPTH), .POST_CNT(POST)) u_smp_capture_packer (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_analog(smp_analog),
      .smp_logic(smp_logic), .trig_pulse(trig_pulse), .ctl_wr(ctl_wr),
      .ctl_data(ctl_data), .stat_req(stat_req), .stat_vld(stat_vld),
      .stat_byte(stat_byte), .dump_req(dump_req), .out_valid(out_valid),
      .out_byte(out_byte), .out_ready(out_ready)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic ctl(input logic [7:0] v);
      @(negedge clk); ctl_wr = 1'b1; ctl_data = v;
      @(negedge clk); ctl_wr = 1'b0; ctl_data = '0;
   endtask

   task automatic query(input int exp, input string tag);
      @(negedge clk); stat_req = 1'b1;
      @(negedge clk); stat_req = 1'b0;
      chk(stat_vld === 1'b1 && int'(stat_byte) == exp, tag,
          stat_vld ? int'(stat_byte) : 32'hdead, exp);
   endtask

   task automatic push(input int a, input int l, input bit rec);
      @(negedge clk); smp_valid = 1'b1; smp_analog = 10'(a); smp_logic = 8'(l);
      @(negedge clk); smp_valid = 1'b0;
      if (rec) begin ha[n] = a; hl[n] = l; n++; end
   endtask

   task automatic pulse_trig();
      @(negedge clk); trig_pulse = 1'b1;
      @(negedge clk); trig_pulse = 1'b0;
   endtask

   task automatic pulse_dump();
      @(negedge clk); dump_req = 1'b1;
      @(negedge clk); dump_req = 1'b0;
   endtask

   task automatic arm_seq();
      ctl(8'h01); ctl(8'h02); ctl(8'h00);
      n = 0;
   endtask

   function automatic int exp_byte(input int k);
      int j = n - DEPTH + k / 3;
      case (k % 3)
         0: return ha[j] & 6'h3f;
         1: return ((hl[j] & 3) << 4) | ((ha[j] >> 6) & 4'hf);
         default: return (hl[j] >> 2) & 6'h3f;
      endcase
   endfunction

   task automatic dump_and_check(input bit stall);
      int k = 0;
      int cyc = 0;
      bit pv = 0;
      bit pr = 1;
      logic [7:0] pb = '0;
      pulse_dump();
      while (k < DEPTH * 3 && cyc < 2000) begin
         out_ready = stall ? ((cyc % 5) != 3 && (cyc % 7) != 2) : 1'b1;
         if (pv && !pr)
            chk(out_valid === 1'b1 && out_byte == pb, "R10 hold", int'(out_byte), int'(pb));
         if (out_valid && out_ready) begin
            chk(out_byte == 8'(exp_byte(k)), $sformatf("R8 R9 byte %0d", k),
                int'(out_byte), exp_byte(k));
            k++;
         end
         pv = out_valid; pr = out_ready; pb = out_byte;
         cyc++;
         @(negedge clk);
      end
      out_ready = 1'b1;
      chk(k == DEPTH * 3, "R8 byte count", k, DEPTH * 3);
      chk(out_valid === 1'b0, "R8 stream ends", int'(out_valid), 0);
      query(8'h10, "R8 idle after dump");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
      query(8'h10, "R1 status idle");

      // dump request while idle is ignored
      pulse_dump();
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(out_valid === 1'b0, "R7 no output from idle", int'(out_valid), 0);
      end
      query(8'h10, "R7 still idle");

      pulse_trig();
      query(8'h10, "R3 trigger ignored in idle");

      ctl(8'h02);
      query(8'h11, "R2 arm from idle");
      ctl(8'h01);
      query(8'h10, "R2 restart to idle");
      ctl(8'h03);
      query(8'h10, "R2 restart wins over arm");
      arm_seq();
      query(8'h11, "R2 arm sequence");
      query(8'h11, "R6 armed code");

      pulse_dump();
      repeat (4) @(negedge clk);
      chk(out_valid === 1'b0, "R7 no output from armed", int'(out_valid), 0);
      query(8'h11, "R7 armed kept");

      for (int s = 0; s < 4; s++) begin
         arm_seq();
         for (int i = 0; i < DEPTH + 3 * s; i++)
            push((i * 37 + s * 101) & 10'h3ff, (i * 13) ^ (s * 29) & 8'hff, 1'b1);
         if (s % 2 == 0) pulse_trig();
         else ctl(8'h08);
         query(8'h12, s % 2 == 0 ? "R3 trigger starts post" : "R4 force from armed");
         ctl(8'h02);
         query(8'h12, "R2 arm ignored in post");
         pulse_dump();
         query(8'h12, "R7 dump ignored in post");
         for (int i = 0; i < POST - 1; i++)
            push((i * 53 + s * 7 + 300) & 10'h3ff, (i * 71 + s) & 8'hff, 1'b1);
         query(8'h12, "R5 not ready one sample early");
         push((s * 211 + 5) & 10'h3ff, (s * 89 + 3) & 8'hff, 1'b1);
         query(8'h16, "R5 R6 data ready");
         for (int i = 0; i < 3; i++) push(10'h3ff, 8'hff, 1'b0);
         pulse_trig();
         query(8'h16, "R5 ready kept");
         dump_and_check(s == 1);
      end

      ctl(8'h08);
      query(8'h12, "R4 force from idle");
      ctl(8'h01);
      query(8'h10, "R2 restart from post");

      // restart aborts a dump in progress
      arm_seq();
      for (int i = 0; i < DEPTH; i++) push(i, i, 1'b1);
      pulse_trig();
      for (int i = 0; i < POST; i++) push(i + 40, i + 40, 1'b1);
      pulse_dump();
      repeat (6) @(negedge clk);
      chk(out_valid === 1'b1, "R11 dump running", int'(out_valid), 1);
      ctl(8'h01);
      chk(out_valid === 1'b0, "R11 abort", int'(out_valid), 0);
      repeat (3) @(negedge clk);
      chk(out_valid === 1'b0, "R11 stays quiet", int'(out_valid), 0);
      query(8'h10, "R11 idle after abort");

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule